// File: doc/BRIEF.md
# Tagged fan-in pipeline fan-out

This block lets several requesters share one fixed-latency compute pipeline. Each requester has its own input port and offers an operand pair `a`, `b` under a valid/ready handshake. A round-robin arbiter picks one requesting port per cycle. It tags the accepted item with that port's index and feeds it into a pipeline of `DEPTH` register stages. The pipeline's arithmetic is a placeholder: the sum `a + b`, truncated to `DATA_W` bits.

The tag travels untouched through every stage. At the last stage it selects the output port whose index equals the tag, so each requester gets back only its own results, in the order it sent them.

Every output port has its own valid/ready handshake. When the item at the head of the pipeline waits on a port that is not ready, the whole pipeline freezes. While it is frozen, no input port sees ready.

Top module: `tag_fanin_pipe`

## Requirements
- R1: While and after reset, every `out_valid_o` bit is low. The arbiter pointer starts at port 0, so when all ports request at once after reset, port 0 is served first.
- R2: The result `z` of an item equals `(a + b) mod 2^DATA_W` for the operands it was accepted with.
- R3: Each result carries an ID equal to the index of the input port that sent it. The ID field for port p is `out_id_o[p*ID_W +: ID_W]`.
- R4: A result is presented only on the output port whose index equals its ID. At most one `out_valid_o` bit is high in any cycle.
- R5: Results for one source leave that source's output port in the order its requests were accepted, with none lost or duplicated.
- R6: An output transfer happens only in a cycle where valid and ready are both high. While valid is high and ready is low, that port keeps valid high and its `z` unchanged in the next cycle.
- R7: With all ports requesting continuously and no stall, grants rotate through port indices in increasing order, wrapping from the last index to 0.
- R8: While the head result is valid and its destination port is not ready, every `in_ready_o` bit is low.
- R9: An item accepted into an empty pipeline that is not stalled shows valid on its output port `DEPTH` cycles after the cycle in which it was accepted.
- R10: At most one `in_ready_o` bit is high at a time, and only on a port whose `in_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NUM_PORTS | Per-port request valid |
| in_ready_o | output | NUM_PORTS | Per-port request accepted |
| in_a_i | input | NUM_PORTS*DATA_W | Operand a; port p in bits p*DATA_W +: DATA_W |
| in_b_i | input | NUM_PORTS*DATA_W | Operand b; port p in bits p*DATA_W +: DATA_W |
| out_valid_o | output | NUM_PORTS | Per-port result valid |
| out_ready_i | input | NUM_PORTS | Per-port result ready |
| out_z_o | output | NUM_PORTS*DATA_W | Result per port; zero when that port is not valid |
| out_id_o | output | NUM_PORTS*ID_W | Source ID per port; zero when that port is not valid |

## Verification
A tag corrupted in any stage shows up `DEPTH` cycles after acceptance. The result then lands on the wrong port, or carries an ID that differs from the port it arrives on, and the per-port scoreboard catches it at that transfer.

A lost or duplicated stage valid bit leaves a scoreboard entry pending at drain time, or produces a result that no request accounts for.

A pointer that does not advance shows within `NUM_PORTS` cycles of contention, because the grant order then breaks the expected rotation. A stall that does not hold shows one cycle later, as a changed or vanished head result, or as an input ready that is high while the head waits.

// File: rtl/tag_pipe_pkg.sv
package tag_pipe_pkg;
  localparam int unsigned DEF_PORTS  = 4;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_DEPTH  = 3;

  function automatic int unsigned id_width(input int unsigned ports);
    return (ports > 1) ? $clog2(ports) : 1;
  endfunction
endpackage

// File: rtl/tag_rr_arb.sv
module tag_rr_arb #(
  parameter int unsigned NUM_PORTS = tag_pipe_pkg::DEF_PORTS,
  localparam int unsigned ID_W     = tag_pipe_pkg::id_width(NUM_PORTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic                 advance_i,
  output logic [NUM_PORTS-1:0] gnt_o,
  output logic [ID_W-1:0]      gnt_idx_o,
  output logic                 gnt_valid_o
);
  logic [ID_W-1:0] ptr_q;

  // first requester at or after the pointer
  always_comb begin
    int j;
    gnt_o       = '0;
    gnt_idx_o   = '0;
    gnt_valid_o = 1'b0;
    for (int i = 0; i < int'(NUM_PORTS); i++) begin
      j = int'(ptr_q) + i;
      if (j >= int'(NUM_PORTS)) j = j - int'(NUM_PORTS);
      if (!gnt_valid_o && req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_o[j]    = 1'b1;
        gnt_idx_o   = ID_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (gnt_valid_o && advance_i) begin
      if (gnt_idx_o == ID_W'(NUM_PORTS - 1)) ptr_q <= '0;
      else                                   ptr_q <= gnt_idx_o + 1'b1;
    end
  end

  // R10: single grant, only to a requester
  p_grant_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/tag_pipe_core.sv
module tag_pipe_core #(
  parameter int unsigned DATA_W = tag_pipe_pkg::DEF_DATA_W,
  parameter int unsigned ID_W   = 2,
  parameter int unsigned DEPTH  = tag_pipe_pkg::DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              in_vld_i,
  input  logic [DATA_W-1:0] in_a_i,
  input  logic [DATA_W-1:0] in_b_i,
  input  logic [ID_W-1:0]   in_id_i,
  output logic              head_vld_o,
  output logic [DATA_W-1:0] head_z_o,
  output logic [ID_W-1:0]   head_id_o
);
  logic              vld_q [DEPTH];
  logic [DATA_W-1:0] z_q   [DEPTH];
  logic [ID_W-1:0]   id_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(DEPTH); s++) vld_q[s] <= 1'b0;
    end else if (advance_i) begin
      vld_q[0] <= in_vld_i;
      for (int s = 1; s < int'(DEPTH); s++) vld_q[s] <= vld_q[s-1];
    end
  end

  // placeholder arithmetic in stage 0, then tag and result ride along
  always_ff @(posedge clk_i) begin
    if (advance_i) begin
      z_q[0]  <= in_a_i + in_b_i;
      id_q[0] <= in_id_i;
      for (int s = 1; s < int'(DEPTH); s++) begin
        z_q[s]  <= z_q[s-1];
        id_q[s] <= id_q[s-1];
      end
    end
  end

  assign head_vld_o = vld_q[DEPTH-1];
  assign head_z_o   = z_q[DEPTH-1];
  assign head_id_o  = id_q[DEPTH-1];

  // R6: a frozen head keeps its payload
  p_head_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_vld_o && !advance_i) |=> (head_vld_o && $stable(head_z_o) && $stable(head_id_o)));
endmodule

// File: rtl/tag_out_router.sv
module tag_out_router #(
  parameter int unsigned NUM_PORTS = tag_pipe_pkg::DEF_PORTS,
  parameter int unsigned DATA_W    = tag_pipe_pkg::DEF_DATA_W,
  localparam int unsigned ID_W     = tag_pipe_pkg::id_width(NUM_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        head_vld_i,
  input  logic [DATA_W-1:0]           head_z_i,
  input  logic [ID_W-1:0]             head_id_i,
  input  logic [NUM_PORTS-1:0]        out_ready_i,
  output logic                        head_ready_o,
  output logic [NUM_PORTS-1:0]        out_valid_o,
  output logic [NUM_PORTS*DATA_W-1:0] out_z_o,
  output logic [NUM_PORTS*ID_W-1:0]   out_id_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign out_valid_o[p]              = head_vld_i && (head_id_i == ID_W'(p));
    assign out_z_o[p*DATA_W +: DATA_W] = out_valid_o[p] ? head_z_i  : '0;
    assign out_id_o[p*ID_W +: ID_W]    = out_valid_o[p] ? head_id_i : '0;
  end

  assign head_ready_o = out_ready_i[head_id_i];

  // R4: one destination at a time
  p_out_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));
endmodule

// File: rtl/tag_fanin_pipe.sv
module tag_fanin_pipe #(
  parameter int unsigned NUM_PORTS = tag_pipe_pkg::DEF_PORTS,
  parameter int unsigned DATA_W    = tag_pipe_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH     = tag_pipe_pkg::DEF_DEPTH,
  localparam int unsigned ID_W     = tag_pipe_pkg::id_width(NUM_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        in_valid_i,
  output logic [NUM_PORTS-1:0]        in_ready_o,
  input  logic [NUM_PORTS*DATA_W-1:0] in_a_i,
  input  logic [NUM_PORTS*DATA_W-1:0] in_b_i,
  output logic [NUM_PORTS-1:0]        out_valid_o,
  input  logic [NUM_PORTS-1:0]        out_ready_i,
  output logic [NUM_PORTS*DATA_W-1:0] out_z_o,
  output logic [NUM_PORTS*ID_W-1:0]   out_id_o
);
  logic [NUM_PORTS-1:0] gnt;
  logic [ID_W-1:0]      gnt_idx;
  logic                 gnt_valid;
  logic                 advance;
  logic                 head_vld, head_ready;
  logic [DATA_W-1:0]    head_z;
  logic [ID_W-1:0]      head_id;
  logic [DATA_W-1:0]    sel_a, sel_b;

  // whole pipe freezes while the head is blocked
  assign advance    = !(head_vld && !head_ready);
  assign in_ready_o = gnt & {NUM_PORTS{advance}};
  assign sel_a      = in_a_i[gnt_idx*DATA_W +: DATA_W];
  assign sel_b      = in_b_i[gnt_idx*DATA_W +: DATA_W];

  tag_rr_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (in_valid_i),
    .advance_i   (advance),
    .gnt_o       (gnt),
    .gnt_idx_o   (gnt_idx),
    .gnt_valid_o (gnt_valid)
  );

  tag_pipe_core #(.DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .advance_i  (advance),
    .in_vld_i   (gnt_valid),
    .in_a_i     (sel_a),
    .in_b_i     (sel_b),
    .in_id_i    (gnt_idx),
    .head_vld_o (head_vld),
    .head_z_o   (head_z),
    .head_id_o  (head_id)
  );

  tag_out_router #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_vld_i   (head_vld),
    .head_z_i     (head_z),
    .head_id_i    (head_id),
    .out_ready_i  (out_ready_i),
    .head_ready_o (head_ready),
    .out_valid_o  (out_valid_o),
    .out_z_o      (out_z_o),
    .out_id_o     (out_id_o)
  );

  // R8: a blocked output closes every input
  p_stall_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_o != '0) && ((out_valid_o & out_ready_i) == '0)) |-> (in_ready_o == '0));

  // R1: nothing leaves right after reset
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_valid_o == '0));
endmodule

// File: tb/tag_fanin_pipe_test.sv
`timescale 1ns/1ps
module tag_fanin_pipe_test;
  localparam int P     = 4;
  localparam int W     = 16;
  localparam int D     = 3;
  localparam int IDW   = 2;
  localparam int ITEMS = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0]   in_valid = '0;
  logic [P-1:0]   in_ready;
  logic [P*W-1:0] in_a = '0, in_b = '0;
  logic [P-1:0]   out_valid;
  logic [P-1:0]   out_ready = '0;
  logic [P*W-1:0] out_z;
  logic [P*IDW-1:0] out_id;

  always #2 clk = ~clk;

  tag_fanin_pipe #(.NUM_PORTS(P), .DATA_W(W), .DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_a_i(in_a), .in_b_i(in_b),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_z_o(out_z), .out_id_o(out_id)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic [W-1:0] exp_mem [P][64];
  int wr [P];
  int rd [P];
  logic [W-1:0] held_z [P];
  bit held [P];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  // driver: one port, holds valid and data until ready
  task automatic drive_port(input int p, input int n);
    logic [W-1:0] a, b;
    int gap;
    for (int i = 0; i < n; i++) begin
      a = W'($urandom);
      b = W'($urandom);
      in_a[p*W +: W] = a;
      in_b[p*W +: W] = b;
      in_valid[p] = 1'b1;
      #1;
      while (!in_ready[p]) begin
        @(negedge clk); #1;
      end
      exp_mem[p][wr[p]] = a + b;
      wr[p]++;
      @(negedge clk);
      in_valid[p] = 1'b0;
      gap = $urandom_range(3);
      repeat (gap) @(negedge clk);
    end
  endtask

  // monitor: random output backpressure, scoreboard pop
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        for (int p = 0; p < P; p++) out_ready[p] = ($urandom_range(3) != 0);
        #1;
        chk($countones(out_valid) <= 1, "R4 onehot out_valid", 32'(out_valid), 0);
        for (int p = 0; p < P; p++) begin
          if (held[p])
            chk(out_valid[p] && out_z[p*W +: W] == held_z[p], "R6 hold under backpressure",
                32'(out_z[p*W +: W]), 32'(held_z[p]));
          held[p] = 1'b0;
          if (out_valid[p]) begin
            chk(out_id[p*IDW +: IDW] == IDW'(p), "R3 id matches port",
                32'(out_id[p*IDW +: IDW]), p);
            if (rd[p] >= wr[p]) chk(1'b0, "R4 result on port with nothing pending", p, 32'hffff);
            else if (out_ready[p]) begin
              chk(out_z[p*W +: W] == exp_mem[p][rd[p]], "R5 R2 in-order sum",
                  32'(out_z[p*W +: W]), 32'(exp_mem[p][rd[p]]));
              rd[p]++;
            end else begin
              held[p] = 1'b1;
              held_z[p] = out_z[p*W +: W];
            end
          end
        end
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired act 0 exp 1");
      summary();
    end
  end

  initial begin
    for (int p = 0; p < P; p++) begin wr[p] = 0; rd[p] = 0; held[p] = 1'b0; end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == '0, "R1 out_valid in reset", 32'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = '1;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == '0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(in_ready == '0, "R10 no ready without valid", 32'(in_ready), 0);

    // R7 / R1: rotation from port 0
    @(negedge clk);
    for (int p = 0; p < P; p++) begin
      in_a[p*W +: W] = W'(p);
      in_b[p*W +: W] = W'(10);
    end
    in_valid = '1;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(in_ready == P'(1 << (k % P)), "R7 R1 round-robin grant", 32'(in_ready), 32'(1 << (k % P)));
      @(negedge clk);
    end
    in_valid = '0;
    repeat (10) @(negedge clk);

    // R9 / R2 / R3: latency into an empty pipe
    in_a[2*W +: W] = 16'h0005;
    in_b[2*W +: W] = 16'h0007;
    in_valid[2] = 1'b1;
    #1;
    chk(in_ready == 4'b0100, "R10 ready to lone requester", 32'(in_ready), 32'h4);
    @(negedge clk);
    in_valid[2] = 1'b0;
    repeat (D - 2) @(negedge clk);
    #1;
    chk(out_valid == '0, "R9 not valid one cycle early", 32'(out_valid), 0);
    @(negedge clk); #1;
    chk(out_valid == 4'b0100, "R9 valid after DEPTH cycles", 32'(out_valid), 32'h4);
    chk(out_z[2*W +: W] == 16'h000c, "R2 sum 5+7", 32'(out_z[2*W +: W]), 32'hc);
    chk(out_id[2*IDW +: IDW] == 2'd2, "R3 id of port 2", 32'(out_id[2*IDW +: IDW]), 2);
    chk(out_z[1*W +: W] == '0, "R4 other port quiet", 32'(out_z[1*W +: W]), 0);
    repeat (3) @(negedge clk);

    // R8 / R6: stall with port 1 blocked
    out_ready[1] = 1'b0;
    in_a[1*W +: W] = 16'hffff;
    in_b[1*W +: W] = 16'h0003;
    in_valid[1] = 1'b1;
    @(negedge clk);
    in_valid[1] = 1'b0;
    repeat (D - 1) @(negedge clk);
    in_a[0*W +: W] = 16'h1234;
    in_b[0*W +: W] = 16'h1111;
    in_valid[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(out_valid == 4'b0010, "R6 head waits on port 1", 32'(out_valid), 32'h2);
      chk(out_z[1*W +: W] == 16'h0002, "R2 wraparound sum held", 32'(out_z[1*W +: W]), 32'h2);
      chk(in_ready == '0, "R8 inputs closed in stall", 32'(in_ready), 0);
      if (k < 2) @(negedge clk);
    end
    out_ready[1] = 1'b1;
    #1;
    chk(in_ready == 4'b0001, "R8 input reopens with ready", 32'(in_ready), 32'h1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1;
    chk(out_valid == '0, "R6 transfer consumed head", 32'(out_valid), 0);
    repeat (D - 1) @(negedge clk);
    #1;
    chk(out_valid == 4'b0001 && out_z[0*W +: W] == 16'h2345, "R2 port 0 result after stall",
        32'(out_z[0*W +: W]), 32'h2345);
    repeat (4) @(negedge clk);

    // random traffic with scoreboard
    mon_en = 1'b1;
    for (int p = 0; p < P; p++) begin
      fork
        automatic int q = p;
        drive_port(q, ITEMS);
      join_none
    end
    wait fork;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (rd[0] == wr[0] && rd[1] == wr[1] && rd[2] == wr[2] && rd[3] == wr[3]) break;
    end
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    for (int p = 0; p < P; p++)
      chk(rd[p] == ITEMS && wr[p] == ITEMS, "R5 all results delivered", rd[p], ITEMS);
    summary();
  end
endmodule